// File: doc/BRIEF.md
# Dual-Width Code-Group Bus Adapter

This block joins a MAC-side parallel bus to the parallel port of a 10-bit serializer/deserializer core. The core carries 8b/10b encoded code groups. Coding itself is not part of this block. A static mode input picks one of two bus formats:

- In full-width mode, one 10-bit code group crosses the bus in each cycle of the reference clock.
- In half-width mode, five wires carry each code group in two halves. Bits 4..0 travel with the rising edge and bits 9..5 with the falling edge that follows.

On transmit, the adapter rebuilds the full 10-bit word for the core. On receive, it splits the core's word back into halves, choosing the half from the clock phase.

A power-on reset puts the receive data bus and the two receive byte clocks into high impedance. Each of those buses has an explicit output-enable, which is also brought out as a port. The mode is latched while the block is held in reset. The outputs are enabled only after a short synchronous release.

Top module: `cg_bus_adapter`

## Requirements
- R1: While `rst_n` is low, `rx_data_o`, `rx_bclk_o` and `rx_bclk_n_o` are high impedance, `rx_data_oe_o` and `rx_bclk_oe_o` are 0, and `core_tx_o` is 0. This holds at once when reset is asserted, with no clock edge needed.
- R2: After `rst_n` rises, the outputs stay disabled through the first rising clock edge. They are enabled from the second rising edge on, and the receive data bus then reads 0.
- R3: `mode_i` (0 = full-width, 1 = half-width) is captured only on rising edges while the outputs are still disabled. Changing it afterwards has no effect until the next reset.
- R4: In full-width mode, a word on `tx_data_i` at rising edge k appears on `core_tx_o` after rising edge k+1.
- R5: In half-width mode, `tx_data_i[4:0]` at rising edge k gives code-group bits 4..0. `tx_data_i[4:0]` at the falling edge that follows gives bits 9..5. The joined word appears on `core_tx_o` after rising edge k+1. `tx_data_i[9:5]` is ignored in this mode.
- R6: In full-width mode, `core_rx_i` sampled at rising edge k is driven on `rx_data_o` for the whole cycle after that edge.
- R7: In half-width mode, for the word sampled from `core_rx_i` at the last rising edge, `rx_data_o[4:0]` shows its bits 4..0 while the clock is high and its bits 9..5 while the clock is low. `rx_data_o[9:5]` is driven 0.
- R8: Once enabled, `rx_bclk_o` follows the reference clock and `rx_bclk_n_o` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mode_i | input | 1 | Bus format select: 0 full-width, 1 half-width |
| tx_data_i | input | 10 | MAC-side transmit bus (only bits 4..0 are used in half-width mode) |
| core_tx_o | output | 10 | Assembled code group to the serializer core |
| core_rx_i | input | 10 | Code group from the deserializer core |
| rx_data_o | output | 10 | MAC-side receive bus, tri-stated in reset |
| rx_data_oe_o | output | 1 | Enable of the receive data bus |
| rx_bclk_o | output | 1 | Receive byte clock, tri-stated in reset |
| rx_bclk_n_o | output | 1 | Inverted receive byte clock, tri-stated in reset |
| rx_bclk_oe_o | output | 1 | Enable of both byte clocks |

## Verification
Random 10-bit words are sent through a transmit-to-receive loopback in both modes, and the bus is sampled in each half of every clock period. In half-width mode, bits 9..5 of the transmit bus are filled with unrelated noise. Random words tell apart a swapped or misplaced half, because the two halves almost never match. Sampling at each clock phase shows whether the receive multiplexer picks the right half. A mode flip in the middle of traffic shows that the latched mode cannot change outside reset. An asynchronous reset taken in the middle of traffic checks the high-impedance and disable behaviour without relying on a clock edge.

// File: rtl/cg_bus_pkg.sv
package cg_bus_pkg;
  typedef enum logic {
    BUS_FULL = 1'b0,
    BUS_HALF = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/cg_rst_release.sv
module cg_rst_release
  import cg_bus_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_n,
  input  logic      mode_i,
  output logic      run_o,
  output bus_mode_e mode_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q, sync_d;
  bus_mode_e     mode_q, mode_d;
  logic          mode_en;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[LAST-1:0], 1'b1};
    end
  endgenerate

  assign mode_en = ~sync_q[LAST];

  always_comb begin
    mode_d = mode_q;
    if (mode_en) mode_d = bus_mode_e'(mode_i);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      mode_q <= BUS_FULL;
    end else begin
      sync_q <= sync_d;
      mode_q <= mode_d;
    end
  end

  assign run_o  = sync_q[LAST];
  assign mode_o = mode_q;

  // R3: mode is frozen once the outputs run
  a_r3_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_o && $past(run_o)) |-> $stable(mode_o));

  // R2: enable rises only after the first release stage was already set
  a_r2_late_enable: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(run_o) |-> $past(sync_q[0]));
endmodule

// File: rtl/cg_tx_pack.sv
module cg_tx_pack
  import cg_bus_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              run_i,
  input  bus_mode_e         mode_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic [WORD_W-1:0] core_tx_o
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [WORD_W-1:0] full_q, full_d, out_q, out_d;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    full_d = full_q;
    out_d  = out_q;
    if (run_i) begin
      lo_d   = tx_data_i[HALF_W-1:0];
      hi_d   = tx_data_i[HALF_W-1:0];
      full_d = tx_data_i;
      out_d  = (mode_i == BUS_HALF) ? {hi_q, lo_q} : full_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      full_q <= '0;
      out_q  <= '0;
    end else begin
      lo_q   <= lo_d;
      full_q <= full_d;
      out_q  <= out_d;
    end
  end

  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  assign core_tx_o = out_q;

  // R4: full word reaches the core two sampled edges later
  a_r4_full_latency: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_i && $past(run_i) && $past(run_i, 2) && mode_i == BUS_FULL)
      |-> core_tx_o == $past(tx_data_i, 2));

  // R5: rising-edge half lands in the low bits
  a_r5_low_half: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_i && $past(run_i) && $past(run_i, 2) && mode_i == BUS_HALF)
      |-> core_tx_o[HALF_W-1:0] == $past(tx_data_i[HALF_W-1:0], 2));
endmodule

// File: rtl/cg_rx_split.sv
module cg_rx_split
  import cg_bus_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              run_i,
  input  bus_mode_e         mode_i,
  input  logic [WORD_W-1:0] core_rx_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] rx_q, rx_d;

  always_comb begin
    rx_d = rx_q;
    if (run_i) rx_d = core_rx_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else        rx_q <= rx_d;
  end

  always_comb begin
    if (mode_i == BUS_HALF)
      data_o = {{(WORD_W-HALF_W){1'b0}},
                clk_i ? rx_q[HALF_W-1:0] : rx_q[WORD_W-1:HALF_W]};
    else
      data_o = rx_q;
  end

  // R6: full-width output carries the word sampled one edge earlier
  a_r6_full_word: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_i && $past(run_i) && mode_i == BUS_FULL) |-> data_o == $past(core_rx_i));

  // R7: upper wires stay low in half-width mode
  a_r7_upper_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_i && mode_i == BUS_HALF) |-> data_o[WORD_W-1:HALF_W] == '0);
endmodule

// File: rtl/cg_bus_adapter.sv
module cg_bus_adapter
  import cg_bus_pkg::*;
#(
  parameter int WORD_W     = 10,
  parameter int REL_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic [WORD_W-1:0] core_tx_o,
  input  logic [WORD_W-1:0] core_rx_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_data_oe_o,
  output logic              rx_bclk_o,
  output logic              rx_bclk_n_o,
  output logic              rx_bclk_oe_o
);
  logic              run;
  bus_mode_e         mode;
  logic [WORD_W-1:0] rx_word;

  cg_rst_release #(.STAGES(REL_STAGES)) u_rel (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .mode_i(mode_i),
    .run_o (run),
    .mode_o(mode)
  );

  cg_tx_pack #(.WORD_W(WORD_W)) u_tx (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .run_i    (run),
    .mode_i   (mode),
    .tx_data_i(tx_data_i),
    .core_tx_o(core_tx_o)
  );

  cg_rx_split #(.WORD_W(WORD_W)) u_rx (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .run_i    (run),
    .mode_i   (mode),
    .core_rx_i(core_rx_i),
    .data_o   (rx_word)
  );

  assign rx_data_oe_o = run;
  assign rx_bclk_oe_o = run;
  assign rx_data_o    = rx_data_oe_o ? rx_word : {WORD_W{1'bz}};
  assign rx_bclk_o    = rx_bclk_oe_o ? clk_i   : 1'bz;
  assign rx_bclk_n_o  = rx_bclk_oe_o ? ~clk_i  : 1'bz;
endmodule

// File: tb/cg_bus_adapter_bench.sv
module cg_bus_adapter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0;
  logic [9:0] tx_data = '0;
  wire  [9:0] core_tx;
  wire  [9:0] rx_data;
  wire        rx_data_oe, rx_bclk, rx_bclk_n, rx_bclk_oe;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cg_bus_adapter u_cg_bus_adapter (
    .clk_i(clk), .rst_n(rst_n), .mode_i(mode_sel), .tx_data_i(tx_data),
    .core_tx_o(core_tx), .core_rx_i(core_tx), .rx_data_o(rx_data),
    .rx_data_oe_o(rx_data_oe), .rx_bclk_o(rx_bclk), .rx_bclk_n_o(rx_bclk_n),
    .rx_bclk_oe_o(rx_bclk_oe)
  );

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(req, rx_data, 10'bz);
    chk(req, {9'd0, rx_bclk}, {9'd0, 1'bz});
    chk(req, {9'd0, rx_bclk_n}, {9'd0, 1'bz});
    chk(req, {8'd0, rx_data_oe, rx_bclk_oe}, 10'd0);
    chk(req, core_tx, 10'd0);
  endtask

  task automatic do_reset(input logic half);
    @(negedge clk); #5;
    rst_n = 1'b0;
    mode_sel = half;
    #1 chk_quiet("R1");
    repeat (3) @(posedge clk);
    #5 chk_quiet("R1");
    @(negedge clk); #5;
    rst_n = 1'b1;
    @(posedge clk); #5;
    chk("R2", {8'd0, rx_data_oe, rx_bclk_oe}, 10'd0);
    @(posedge clk); #5;
    chk("R2", {8'd0, rx_data_oe, rx_bclk_oe}, 10'd3);
    chk("R2", rx_data, 10'd0);
    @(negedge clk); #5;
  endtask

  task automatic run_traffic(input logic half, input int n);
    logic [9:0] w[$];
    for (int i = 0; i <= n; i++) w.push_back(10'($urandom));
    tx_data = half ? {5'($urandom), w[0][4:0]} : w[0];
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #5;
      if (c >= 1) begin
        if (c > n / 2) chk("R3", core_tx, w[c-1]);
        else           chk(half ? "R5" : "R4", core_tx, w[c-1]);
      end
      if (c >= 2) begin
        if (half) chk("R7", rx_data, {5'd0, w[c-2][4:0]});
        else      chk("R6", rx_data, w[c-2]);
      end
      chk("R8", {8'd0, rx_bclk, rx_bclk_n}, 10'd2);
      if (half) tx_data = {5'($urandom), w[c][9:5]};
      if (c == n / 2) mode_sel = ~mode_sel;  // R3: late change ignored
      @(negedge clk); #5;
      if (c >= 2) begin
        if (half) chk("R7", rx_data, {5'd0, w[c-2][9:5]});
        else      chk("R6", rx_data, w[c-2]);
      end
      chk("R8", {8'd0, rx_bclk, rx_bclk_n}, 10'd1);
      tx_data = half ? {5'($urandom), w[c+1][4:0]} : w[c+1];
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3 chk_quiet("R1");
    do_reset(1'b0);
    run_traffic(1'b0, 40);
    do_reset(1'b1);
    run_traffic(1'b1, 40);
    do_reset(1'b0);
    run_traffic(1'b0, 12);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule